// File: doc/BRIEF.md
# Chained-Descriptor Frame Injection DMA

This block is a single-channel DMA engine that moves outgoing frames from memory onto a byte-wide frame stream. Software builds the work in memory as a chain of control blocks. Each control block starts with a link word to the next block and an unused info word. A configurable number of data-block slots follows. Each slot is a pair of words: a data pointer, then a status word. Software fills in the status word ahead of time with a length, an offset and start/end-of-frame flags. For each slot, the engine reads the status, fetches the described bytes one memory word at a time, and streams them out with frame markers. It then writes the status back with a completion bit set. Software may reuse a slot only after that bit is set.

A link value of 0x1 marks the tail of the chain, and the engine waits there. The first transfer is started with an activate command that carries the start address. Later work is added by writing a new control block, pointing the old tail's link at it, and pulsing reload. The engine then re-reads the tail link and carries on. A deactivate command clears the channel's active state. No further control block is fetched once the data block in flight has finished.

Top module: `frame_inj_dma`

## Requirements
- R1: After reset, `tx_valid_o`, `mem_req_o` and `active_o` are all 0.
- R2: An activate pulse is accepted only while the engine is idle. It sets `active_o` and processes the control block at `start_addr_i`. Byte layout of a control block at address A: link word at A, info word at A+4, and for slot i, the data pointer at A+8+8i and the status at A+12+8i. Slots 0 to `db_cnt_i`-1 are processed, and a count of 0 acts as 1.
- R3: Status fields: length in bits 15:0, start-of-frame flag in bit 16, end-of-frame flag in bit 17, offset in bits 31:20. The engine emits exactly length bytes, starting at byte address pointer+offset. Memory is read as aligned 32-bit words, and byte k of a word is bits 8k+7:8k.
- R4: `tx_sof_o` is high only with the first byte of a slot whose start flag is set. `tx_eof_o` is high only with the last byte of a slot whose end flag is set.
- R5: After a slot's bytes are accepted, its status word is written back unchanged except that bit 19 (done) is set.
- R6: A slot with length 0 emits no byte and is still written back with bit 19 set.
- R7: After the last slot, the link word is read. A value of 0x1 parks the engine with no memory traffic. Any other value is taken as the next control block address.
- R8: A reload pulse while parked re-reads the tail link. The engine continues if the link was changed and stays parked with no output if it is still 0x1.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, data and markers stay unchanged on the next cycle.
- R10: A deactivate pulse clears `active_o` on the next cycle. After it, no further control block is fetched and a reload has no effect, while a later activate is accepted.
- R11: An activate pulse while the channel is active is ignored: no new block is fetched from its address.
- R12: A memory request holds its address, write flag and write data until `mem_ack_i` is seen. A read response is taken from `mem_rdata_i` in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| activate_i | input | 1 | Start pulse, accepted when idle |
| start_addr_i | input | ADDR_W | First control block address for activate |
| reload_i | input | 1 | Re-read the tail link |
| deactivate_i | input | 1 | Clear the channel active state |
| db_cnt_i | input | IDX_W | Data-block slots per control block |
| active_o | output | 1 | Channel active state |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_data_o | output | 8 | Stream byte |
| tx_sof_o | output | 1 | First byte of frame |
| tx_eof_o | output | 1 | Last byte of frame |

## Verification
Output timing depends on memory acknowledge latency and stream backpressure. Each fetched word therefore appears as bytes starting one cycle after its acknowledge, and each status write-back follows only after the slot's last byte has been accepted. The checks follow that ordering rather than fixed cycle counts. Every accepted byte and its markers are compared, on the cycle of the handshake, against a queue that the bench builds from the slot descriptions. A held request or held stream byte is compared against its value one cycle earlier. Status words and the absence of stray output are checked only after a quiet window of 40 cycles with the expectation queue empty, which gives every pending write-back time to land.

// File: rtl/fid_pkg.sv
package fid_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam int LANE_W = $clog2(BYTES);
  localparam logic [WORD_W-1:0] END_OF_CHAIN = 32'h1;

  typedef struct packed {
    logic [11:0] ofs;
    logic        done;
    logic        irq;
    logic        eof;
    logic        sof;
    logic [15:0] len;
  } slot_stat_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_STAT, S_RD_PTR, S_RD_WORD, S_EMIT, S_WR_STAT, S_RD_NEXT, S_PARK
  } seq_st_e;
endpackage

// File: rtl/fid_ctl.sv
module fid_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic activate_i,
  input  logic deactivate_i,
  input  logic reload_i,
  input  logic eng_idle_i,
  input  logic pend_clr_i,
  output logic go_o,
  output logic active_o,
  output logic reload_pend_o
);
  logic active_q, pend_q;

  assign go_o = activate_i && !deactivate_i && !active_q && eng_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (deactivate_i)  active_q <= 1'b0;
      else if (go_o)     active_q <= 1'b1;
      // set wins over clear so a late reload is never lost
      if (deactivate_i)                 pend_q <= 1'b0;
      else if (reload_i && active_q)    pend_q <= 1'b1;
      else if (pend_clr_i)              pend_q <= 1'b0;
    end
  end

  assign active_o      = active_q;
  assign reload_pend_o = pend_q;

  a_r10_deact_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deactivate_i |=> !active_o);
  a_r11_act_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !deactivate_i |=> active_o);
endmodule

// File: rtl/fid_emit.sv
module fid_emit
  import fid_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] ld_word_i,
  input  logic [LANE_W-1:0] ld_lane_i,
  input  logic [LANE_W:0]   ld_cnt_i,
  input  logic              ld_sof_i,
  input  logic              ld_eof_i,
  output logic              busy_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o
);
  logic              busy_q, sof_q, eof_q;
  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;
  logic [LANE_W:0]   left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
      word_q <= '0;
      lane_q <= '0;
      left_q <= '0;
    end else if (ld_i) begin
      busy_q <= 1'b1;
      word_q <= ld_word_i;
      lane_q <= ld_lane_i;
      left_q <= ld_cnt_i;
      sof_q  <= ld_sof_i;
      eof_q  <= ld_eof_i;
    end else if (busy_q && tx_ready_i) begin
      lane_q <= lane_q + 1'b1;
      left_q <= left_q - 1'b1;
      sof_q  <= 1'b0;
      if (left_q == 1) busy_q <= 1'b0;
    end
  end

  assign busy_o     = busy_q;
  assign tx_valid_o = busy_q;
  assign tx_data_o  = word_q[8*lane_q +: 8];
  assign tx_sof_o   = busy_q && sof_q;
  assign tx_eof_o   = busy_q && eof_q && (left_q == 1);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) &&
                                  $stable(tx_sof_o) && $stable(tx_eof_o));
  a_r4_sof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_sof_o |=> !tx_sof_o);
  a_r3_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> !busy_q && ld_cnt_i != 0);
endmodule

// File: rtl/fid_seq.sv
module fid_seq
  import fid_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              active_i,
  input  logic              reload_pend_i,
  input  logic [IDX_W-1:0]  db_cnt_i,
  output logic              pend_clr_o,
  output logic              idle_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              ld_o,
  output logic [WORD_W-1:0] ld_word_o,
  output logic [LANE_W-1:0] ld_lane_o,
  output logic [LANE_W:0]   ld_cnt_o,
  output logic              ld_sof_o,
  output logic              ld_eof_o,
  input  logic              emit_busy_i
);
  seq_st_e           st_q;
  logic [ADDR_W-1:0] cb_q, cur_q, slot_addr;
  logic [IDX_W-1:0]  idx_q;
  slot_stat_t        stat_q, rd_stat;
  logic [15:0]       left_q;
  logic              first_q, last_db;
  logic [LANE_W:0]   room, take;

  assign rd_stat   = slot_stat_t'(mem_rdata_i);
  assign slot_addr = cb_q + ADDR_W'(8) + (ADDR_W'(idx_q) << 3);
  assign last_db   = ({1'b0, idx_q} + 1'b1) >= {1'b0, db_cnt_i};
  assign room      = (LANE_W+1)'(BYTES) - {1'b0, cur_q[LANE_W-1:0]};
  assign take      = (left_q < 16'(room)) ? left_q[LANE_W:0] : room;

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = cb_q;
    unique case (st_q)
      S_RD_STAT: begin mem_req_o = 1'b1; mem_addr_o = slot_addr + ADDR_W'(4); end
      S_RD_PTR:  begin mem_req_o = 1'b1; mem_addr_o = slot_addr; end
      S_RD_WORD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {cur_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      end
      S_WR_STAT: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = slot_addr + ADDR_W'(4);
      end
      S_RD_NEXT: mem_req_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    mem_wdata_o = stat_q;
    mem_wdata_o[19] = 1'b1;
  end

  assign ld_o      = (st_q == S_RD_WORD) && mem_ack_i;
  assign ld_word_o = mem_rdata_i;
  assign ld_lane_o = cur_q[LANE_W-1:0];
  assign ld_cnt_o  = take;
  assign ld_sof_o  = first_q && stat_q.sof;
  assign ld_eof_o  = (left_q == 16'(take)) && stat_q.eof;
  assign idle_o    = (st_q == S_IDLE);
  assign pend_clr_o = ((st_q == S_WR_STAT) && mem_ack_i && active_i && last_db) ||
                      ((st_q == S_PARK) && active_i && reload_pend_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cb_q    <= '0;
      cur_q   <= '0;
      idx_q   <= '0;
      stat_q  <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (go_i) begin
          cb_q  <= start_addr_i;
          idx_q <= '0;
          st_q  <= S_RD_STAT;
        end
        S_RD_STAT: if (mem_ack_i) begin
          stat_q <= rd_stat;
          st_q   <= (rd_stat.len == 0) ? S_WR_STAT : S_RD_PTR;
        end
        S_RD_PTR: if (mem_ack_i) begin
          cur_q   <= ADDR_W'(mem_rdata_i) + ADDR_W'(stat_q.ofs);
          left_q  <= stat_q.len;
          first_q <= 1'b1;
          st_q    <= S_RD_WORD;
        end
        S_RD_WORD: if (mem_ack_i) begin
          cur_q   <= cur_q + ADDR_W'(take);
          left_q  <= left_q - 16'(take);
          first_q <= 1'b0;
          st_q    <= S_EMIT;
        end
        S_EMIT: if (!emit_busy_i) st_q <= (left_q == 0) ? S_WR_STAT : S_RD_WORD;
        S_WR_STAT: if (mem_ack_i) begin
          if (!active_i)    st_q <= S_IDLE;
          else if (last_db) st_q <= S_RD_NEXT;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_RD_STAT;
          end
        end
        S_RD_NEXT: if (mem_ack_i) begin
          if (!active_i)                          st_q <= S_IDLE;
          else if (mem_rdata_i == END_OF_CHAIN)   st_q <= S_PARK;
          else begin
            cb_q  <= ADDR_W'(mem_rdata_i);
            idx_q <= '0;
            st_q  <= S_RD_STAT;
          end
        end
        S_PARK: begin
          if (!active_i)          st_q <= S_IDLE;
          else if (reload_pend_i) st_q <= S_RD_NEXT;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));
  a_r5_write_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[19] && !emit_busy_i);
  a_r7_park_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PARK) |-> !mem_req_o && !emit_busy_i);
endmodule

// File: rtl/frame_inj_dma.sv
module frame_inj_dma
  import fid_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_DB = 15,
  localparam int IDX_W = $clog2(MAX_DB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              activate_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              reload_i,
  input  logic              deactivate_i,
  input  logic [IDX_W-1:0]  db_cnt_i,
  output logic              active_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o
);
  logic              go, idle, pend, pend_clr, ld, ld_sof, ld_eof, busy;
  logic [WORD_W-1:0] ld_word;
  logic [LANE_W-1:0] ld_lane;
  logic [LANE_W:0]   ld_cnt;

  fid_ctl u_ctl (
    .clk_i, .rst_ni, .activate_i, .deactivate_i, .reload_i,
    .eng_idle_i(idle), .pend_clr_i(pend_clr), .go_o(go),
    .active_o, .reload_pend_o(pend)
  );

  fid_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .go_i(go), .start_addr_i, .active_i(active_o),
    .reload_pend_i(pend), .db_cnt_i, .pend_clr_o(pend_clr), .idle_o(idle),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .ld_o(ld), .ld_word_o(ld_word), .ld_lane_o(ld_lane), .ld_cnt_o(ld_cnt),
    .ld_sof_o(ld_sof), .ld_eof_o(ld_eof), .emit_busy_i(busy)
  );

  fid_emit u_emit (
    .clk_i, .rst_ni, .ld_i(ld), .ld_word_i(ld_word), .ld_lane_i(ld_lane),
    .ld_cnt_i(ld_cnt), .ld_sof_i(ld_sof), .ld_eof_i(ld_eof), .busy_o(busy),
    .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_sof_o, .tx_eof_o
  );

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !mem_req_o && !tx_valid_o);
endmodule

// File: tb/sim_frame_inj_dma.sv
module sim_frame_inj_dma;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        activate = 0, reload = 0, deactivate = 0;
  logic [31:0] start_addr = '0;
  logic [3:0]  db_cnt = 4'd2;
  logic        active, mem_req, mem_we, mem_ack, tx_valid, tx_ready, tx_sof, tx_eof;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;

  frame_inj_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .activate_i(activate), .start_addr_i(start_addr),
    .reload_i(reload), .deactivate_i(deactivate), .db_cnt_i(db_cnt), .active_o(active),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_sof_o(tx_sof), .tx_eof_o(tx_eof)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:511];
  logic [9:0]  exp_q[$];          // {sof, eof, data}
  logic [31:0] st_addr_q[$], st_val_q[$];
  string       st_tag_q[$];
  logic [15:0] lfsr = 16'hACE1;
  bit          bp = 0;
  logic [2:0]  cyc = '0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'((a * 13) + 7);
  endfunction

  function automatic logic [31:0] mk(input int len, input bit s, input bit e, input int ofs);
    return {12'(ofs), 2'b00, e, s, 16'(len)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory: registered acknowledge with periodic stalls
  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      if (mem_req && mem_ack && mem_we) mem[mem_addr[10:2]] <= mem_wdata;
      mem_ack   <= mem_req && !mem_ack && (cyc != 3'd5);
      mem_rdata <= mem[mem_addr[10:2]];
    end
  end

  always @(posedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= bp ? lfsr[0] : 1'b1;
  end

  // stream and memory-port monitor
  logic        hold_p = 0, req_hold_p = 0;
  logic [9:0]  out_p;
  logic [32:0] req_p;
  always @(negedge clk) if (rst_n) begin
    if (hold_p)
      chk(tx_valid && {tx_sof, tx_eof, tx_data} == out_p, "R9 held byte changed",
          {22'd0, tx_sof, tx_eof, tx_data}, {22'd0, out_p});
    if (req_hold_p)
      chk(mem_req && {mem_we, mem_addr} == req_p, "R12 request changed before ack",
          mem_addr, req_p[31:0]);
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0)
        chk(0, "R3 unexpected byte", {22'd0, tx_sof, tx_eof, tx_data}, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({tx_sof, tx_eof, tx_data} == e, "R3/R4 byte or marker",
            {22'd0, tx_sof, tx_eof, tx_data}, {22'd0, e});
      end
    end
    hold_p     = tx_valid && !tx_ready;
    out_p      = {tx_sof, tx_eof, tx_data};
    req_hold_p = mem_req && !mem_ack;
    req_p      = {mem_we, mem_addr};
  end

  task automatic set_db(input logic [31:0] cb, input int i, input logic [31:0] ptr,
                        input logic [31:0] stat, input bit expect_it, input string tag);
    mem[(cb + 8 + 8*i) >> 2]  = ptr;
    mem[(cb + 12 + 8*i) >> 2] = stat;
    if (expect_it) begin
      for (int k = 0; k < int'(stat[15:0]); k++)
        exp_q.push_back({stat[16] && k == 0, stat[17] && k == int'(stat[15:0]) - 1,
                         pat(ptr + stat[31:20] + k)});
      st_addr_q.push_back(cb + 12 + 8*i);
      st_val_q.push_back(stat | 32'h80000);
      st_tag_q.push_back(tag);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) activate = 1; else if (which == 1) reload = 1; else deactivate = 1;
    @(negedge clk);
    activate = 0; reload = 0; deactivate = 0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R3 missing bytes", exp_q.size(), 0);
    while (st_addr_q.size() != 0) begin
      logic [31:0] a, v;
      string t;
      a = st_addr_q.pop_front(); v = st_val_q.pop_front(); t = st_tag_q.pop_front();
      chk(mem[a >> 2] == v, t, mem[a >> 2], v);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 512; w++)
      mem[w] = {pat(4*w + 3), pat(4*w + 2), pat(4*w + 1), pat(4*w)};
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R1 reset valid", tx_valid, 0);
    chk(!mem_req, "R1 reset request", mem_req, 0);
    chk(!active, "R1 reset active", active, 0);
    rst_n = 1;

    // R2 R3 R5 R6 R7: one frame plus an empty slot, chain ends
    mem[0] = 32'h1;
    set_db(32'h000, 0, 32'h100, mk(5, 1, 1, 0), 1, "R5 status done");
    set_db(32'h000, 1, 32'h200, mk(0, 0, 0, 0), 1, "R6 empty slot done");
    start_addr = 32'h000;
    pulse(0);
    chk(active, "R2 active after activate", active, 1);
    settle();
    chk(!mem_req, "R7 parked with no traffic", mem_req, 0);

    // R8 R3 R4 R9: link a new block, offsets, frame over two slots, backpressure
    mem[32'h40 >> 2] = 32'h1;
    set_db(32'h040, 0, 32'h300, mk(3, 1, 0, 2), 1, "R5 status done sof slot");
    set_db(32'h040, 1, 32'h380, mk(9, 0, 1, 5), 1, "R5 status done eof slot");
    mem[0] = 32'h040;
    bp = 1;
    pulse(1);
    settle();

    // R8: reload with tail still unlinked
    pulse(1);
    settle();
    chk(!mem_req && !tx_valid, "R8 still parked", {mem_req, tx_valid}, 0);

    // R11: activate while active is ignored
    mem[32'h80 >> 2] = 32'h1;
    set_db(32'h080, 0, 32'h3C0, mk(4, 1, 1, 0), 0, "");
    start_addr = 32'h080;
    pulse(0);
    settle();
    chk(mem[32'h8C >> 2] == mk(4, 1, 1, 0), "R11 block untouched", mem[32'h8C >> 2], mk(4, 1, 1, 0));

    // R10: deactivate, then reload must not fetch
    pulse(2);
    chk(!active, "R10 inactive after deactivate", active, 0);
    mem[32'hC0 >> 2] = 32'h1;
    set_db(32'h0C0, 0, 32'h3E0, mk(2, 1, 1, 0), 0, "");
    mem[32'h40 >> 2] = 32'h0C0;
    pulse(1);
    settle();
    chk(mem[32'hCC >> 2] == mk(2, 1, 1, 0), "R10 no fetch after deactivate",
        mem[32'hCC >> 2], mk(2, 1, 1, 0));

    // R2: re-activate with one slot per block
    db_cnt = 4'd1;
    set_db(32'h080, 0, 32'h3C0, mk(4, 1, 1, 0), 1, "R2 reactivated block done");
    start_addr = 32'h080;
    pulse(0);
    chk(active, "R2 active after reactivate", active, 1);
    settle();

    // R7 R2: two-block chain, three slots, unaligned pointers, backpressure
    db_cnt = 4'd3;
    mem[32'hA0 >> 2] = 32'h0E0;
    set_db(32'h0A0, 0, 32'h400, mk(1, 1, 1, 0), 1, "R4 one-byte frame done");
    set_db(32'h0A0, 1, 32'h410, mk(6, 1, 0, 1), 1, "R5 status done");
    set_db(32'h0A0, 2, 32'h420, mk(2, 0, 1, 0), 1, "R5 status done");
    mem[32'hE0 >> 2] = 32'h1;
    set_db(32'h0E0, 0, 32'h428, mk(0, 1, 1, 0), 1, "R6 empty slot done");
    set_db(32'h0E0, 1, 32'h430, mk(4, 1, 1, 7), 1, "R7 followed link done");
    set_db(32'h0E0, 2, 32'h441, mk(8, 1, 1, 0), 1, "R3 unaligned pointer done");
    mem[32'h80 >> 2] = 32'h0A0;
    pulse(1);
    settle();
    chk(!mem_req, "R7 parked after chain", mem_req, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule